// File: doc/BRIEF.md
# DMA Transfer Hierarchy Sequencer with Interrupt Selection

This block sequences one DMA channel through a nested transfer hierarchy. The beats that the channel moves are grouped into fragments, fragments into blocks, blocks into transactions, and transactions into a link-list. The block counts the acknowledged beats and emits a one-cycle done pulse at each level of the hierarchy. It also ends the current peripheral request at the level chosen by the request mode, and it drives a sticky interrupt line selected by a programmed interrupt type. Address generation and bus protocol belong to other logic. This block only counts beats and raises events.

A peripheral request arms the channel if the programmed configuration is valid. Once armed, the channel counts beats until the request-complete boundary. It then disarms and waits for the next request. The counters keep their position between requests, so that consecutive requests walk through the hierarchy. A request that arrives with an invalid configuration is refused, and it produces a configuration-error event.

Top module: `dma_hier_seq`

## Requirements
- R1: A configuration is invalid when any of the fragment, block, transaction or list lengths is zero, when the fragment length exceeds the block length, or when the block length exceeds the transaction length. A request that arrives while the channel is idle with an invalid configuration does not arm the channel and raises a configuration-error event.
- R2: `frag_done_o` pulses on the accepted beat that completes `frag_len_i` beats of the current fragment. It also pulses on a beat that ends a block, so the last fragment of a block may be shorter than `frag_len_i`.
- R3: `blk_done_o` pulses on the beat that completes `blk_len_i` beats of the block, or on the beat that ends a transaction. It is always accompanied by `frag_done_o` in the same cycle.
- R4: `trans_done_o` pulses on the beat that completes `trans_len_i` beats, and it is accompanied by `blk_done_o` and `frag_done_o` in the same cycle.
- R5: `list_done_o` pulses together with the `trans_done_o` that completes `list_len_i` transactions.
- R6: `req_done_o` pulses with the done event that `req_mode_i` selects: 0 selects the fragment, 1 the block, 2 the transaction and 3 the link-list. After that beat the channel is idle.
- R7: While the channel is idle, beat acknowledges are ignored and no done pulse appears. A request that arrives while the channel is armed is ignored.
- R8: `irq_type_i` selects the event that sets `irq_o` one cycle after the event. The codes are 0 none, 1 fragment, 2 block, 3 block or fragment, 4 transaction, 5 transaction or fragment, 6 transaction or block, 7 link-list and 8 configuration error. Codes 9 to 15 select no event.
- R9: `irq_o` stays high until a cycle with `irq_clr_i` high. If a selected event occurs in the same cycle as the clear, `irq_o` stays set.
- R10: During reset and right after it, all outputs are low and the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Peripheral request, arms the channel when it is idle |
| beat_ack_i | input | 1 | One beat transferred this cycle |
| frag_len_i | input | CNT_W | Beats per fragment |
| blk_len_i | input | CNT_W | Beats per block |
| trans_len_i | input | CNT_W | Beats per transaction |
| list_len_i | input | CNT_W | Transactions per link-list |
| req_mode_i | input | 2 | Request-complete level |
| irq_type_i | input | 4 | Interrupt source selection |
| irq_clr_i | input | 1 | Clears the interrupt line |
| frag_done_o | output | 1 | Fragment completed |
| blk_done_o | output | 1 | Block completed |
| trans_done_o | output | 1 | Transaction completed |
| list_done_o | output | 1 | Link-list completed |
| req_done_o | output | 1 | Current peripheral request completed |
| irq_o | output | 1 | Sticky interrupt |

## Verification
A counter that is off by one shows up at the ports on the first beat that should have closed a level. The done pulse then comes one beat early or late, and this is visible within one fragment length of the fault. A wrong armed state appears as done pulses while the channel is idle, or as missing pulses after a request, in the cycle of the next beat. A wrong interrupt state shows on `irq_o` one cycle after the event, or at the first clear. A behavioural model compares every output on every cycle across all request modes and interrupt codes, so a divergence is reported in the cycle where it first becomes visible.

// File: rtl/dhs_pkg.sv
// Shared codes for the DMA transfer hierarchy sequencer.
// Assumes: the encodings below are the programming interface of the block.
package dhs_pkg;

    typedef enum logic [1:0] {
        RQ_FRAG  = 2'd0,
        RQ_BLOCK = 2'd1,
        RQ_TRANS = 2'd2,
        RQ_LIST  = 2'd3
    } req_mode_e;

    typedef enum logic [3:0] {
        IT_NONE       = 4'd0,
        IT_FRAG       = 4'd1,
        IT_BLK        = 4'd2,
        IT_BLK_FRAG   = 4'd3,
        IT_TRANS      = 4'd4,
        IT_TRANS_FRAG = 4'd5,
        IT_TRANS_BLK  = 4'd6,
        IT_LIST       = 4'd7,
        IT_CFGERR     = 4'd8
    } irq_type_e;

    // One-cycle completion events of the hierarchy
    typedef struct packed {
        logic frag;
        logic blk;
        logic trans;
        logic list;
        logic cfgerr;
    } evt_t;

    localparam int unsigned NUM_LEVELS = 4;

endpackage

// File: rtl/dhs_cfg_check.sv
// Decides whether the programmed lengths form a usable hierarchy.
// Assumes: lengths are held stable while the channel is armed.
module dhs_cfg_check #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] frag_len_i,
    input  logic [CNT_W-1:0] blk_len_i,
    input  logic [CNT_W-1:0] trans_len_i,
    input  logic [CNT_W-1:0] list_len_i,
    output logic             cfg_ok_o
);

    // Every length non-zero and the levels properly nested
    always_comb begin
        cfg_ok_o = (frag_len_i != '0) && (blk_len_i != '0) &&
                   (trans_len_i != '0) && (list_len_i != '0) &&
                   (frag_len_i <= blk_len_i) && (blk_len_i <= trans_len_i);
    end

endmodule

// File: rtl/dhs_level_cnt.sv
// Position counter for one hierarchy level: advances on adv_i, returns to
// zero when wrap_i accompanies the advance, and flags the last position.
// Assumes: len_i is non-zero whenever adv_i can be high.
module dhs_level_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    // Track the position inside the current unit of this level
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (adv_i)  cnt_q <= wrap_i ? '0 : cnt_q + 1'b1;
    end

    // The next advance closes the unit
    assign last_o = (cnt_q == len_i - 1'b1);

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && wrap_i) |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/dhs_irq_gen.sv
// Selects the interrupt source from the programmed type and keeps a sticky line.
// Assumes: events are single-cycle pulses; unknown type codes select nothing.
module dhs_irq_gen
    import dhs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  evt_t       evt_i,
    input  logic [3:0] irq_type_i,
    input  logic       irq_clr_i,
    output logic       irq_o
);

    logic sel_ev;
    logic irq_q;

    // Map the type code onto the event combination it watches
    always_comb begin
        case (irq_type_i)
            IT_FRAG:       sel_ev = evt_i.frag;
            IT_BLK:        sel_ev = evt_i.blk;
            IT_BLK_FRAG:   sel_ev = evt_i.blk | evt_i.frag;
            IT_TRANS:      sel_ev = evt_i.trans;
            IT_TRANS_FRAG: sel_ev = evt_i.trans | evt_i.frag;
            IT_TRANS_BLK:  sel_ev = evt_i.trans | evt_i.blk;
            IT_LIST:       sel_ev = evt_i.list;
            IT_CFGERR:     sel_ev = evt_i.cfgerr;
            default:       sel_ev = 1'b0;
        endcase
    end

    // Sticky line: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (irq_q & ~irq_clr_i) | sel_ev;
    end

    assign irq_o = irq_q;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr_i) |=> irq_q); // R9
    AST_IRQ_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ev |=> irq_q); // R9
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(sel_ev)); // R8

endmodule

// File: rtl/dma_hier_seq.sv
// DMA transfer hierarchy sequencer: counts accepted beats into fragments,
// blocks, transactions and link-lists, ends peripheral requests at the level
// the request mode names, and raises a selectable sticky interrupt.
// Assumes: configuration inputs change only while idle at a list boundary
// (or under reset); beats arrive only through beat_ack_i.
module dma_hier_seq
    import dhs_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             beat_ack_i,
    input  logic [CNT_W-1:0] frag_len_i,
    input  logic [CNT_W-1:0] blk_len_i,
    input  logic [CNT_W-1:0] trans_len_i,
    input  logic [CNT_W-1:0] list_len_i,
    input  logic [1:0]       req_mode_i,
    input  logic [3:0]       irq_type_i,
    input  logic             irq_clr_i,
    output logic             frag_done_o,
    output logic             blk_done_o,
    output logic             trans_done_o,
    output logic             list_done_o,
    output logic             req_done_o,
    output logic             irq_o
);

    localparam int unsigned LV_FRAG  = 0;
    localparam int unsigned LV_BLK   = 1;
    localparam int unsigned LV_TRANS = 2;
    localparam int unsigned LV_LIST  = 3;

    logic                 cfg_ok;
    logic                 armed_q;
    logic                 beat;
    logic                 req_done;
    logic [CNT_W-1:0]     lens [NUM_LEVELS];
    logic [NUM_LEVELS-1:0] adv, wrap, last;
    evt_t                 evt;

    dhs_cfg_check #(.CNT_W(CNT_W)) u_cfg (
        .frag_len_i  (frag_len_i),
        .blk_len_i   (blk_len_i),
        .trans_len_i (trans_len_i),
        .list_len_i  (list_len_i),
        .cfg_ok_o    (cfg_ok)
    );

    // Gather the per-level lengths in level order
    always_comb begin
        lens[LV_FRAG]  = frag_len_i;
        lens[LV_BLK]   = blk_len_i;
        lens[LV_TRANS] = trans_len_i;
        lens[LV_LIST]  = list_len_i;
    end

    // A beat counts only while a request is open
    assign beat = armed_q & beat_ack_i;

    // Events cascade downward: a higher level closing closes all below it
    always_comb begin
        evt.trans  = beat & last[LV_TRANS];
        evt.blk    = beat & (last[LV_BLK] | last[LV_TRANS]);
        evt.frag   = beat & (last[LV_FRAG] | last[LV_BLK] | last[LV_TRANS]);
        evt.list   = evt.trans & last[LV_LIST];
        evt.cfgerr = req_i & ~armed_q & ~cfg_ok;
    end

    // Advance and wrap controls for each level counter
    always_comb begin
        adv[LV_FRAG]   = beat;
        adv[LV_BLK]    = beat;
        adv[LV_TRANS]  = beat;
        adv[LV_LIST]   = evt.trans;
        wrap[LV_FRAG]  = evt.frag;
        wrap[LV_BLK]   = evt.blk;
        wrap[LV_TRANS] = evt.trans;
        wrap[LV_LIST]  = evt.list;
    end

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        dhs_level_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (adv[g]),
            .wrap_i (wrap[g]),
            .len_i  (lens[g]),
            .last_o (last[g])
        );
    end

    // Pick the level at which the current request ends
    always_comb begin
        case (req_mode_i)
            RQ_FRAG:  req_done = evt.frag;
            RQ_BLOCK: req_done = evt.blk;
            RQ_TRANS: req_done = evt.trans;
            default:  req_done = evt.list;
        endcase
    end

    // Open a request on a valid idle request, close it at its boundary
    always_ff @(posedge clk) begin
        if (!rst_n)                       armed_q <= 1'b0;
        else if (armed_q && req_done)     armed_q <= 1'b0;
        else if (!armed_q && req_i && cfg_ok) armed_q <= 1'b1;
    end

    dhs_irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .irq_type_i (irq_type_i),
        .irq_clr_i  (irq_clr_i),
        .irq_o      (irq_o)
    );

    assign frag_done_o  = evt.frag;
    assign blk_done_o   = evt.blk;
    assign trans_done_o = evt.trans;
    assign list_done_o  = evt.list;
    assign req_done_o   = req_done;

    AST_CFG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !armed_q && !cfg_ok) |=> !armed_q); // R1
    AST_REQ_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        req_done_o |=> !armed_q); // R6
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !(frag_done_o || req_done_o)); // R7
    AST_LIST_WITH_TRANS: assert property (@(posedge clk) disable iff (!rst_n)
        list_done_o |-> (trans_done_o && blk_done_o)); // R5

endmodule

// File: tb/dma_hier_seq_tb.sv
module dma_hier_seq_tb;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0, beat_ack_i = 1'b0, irq_clr_i = 1'b0;
    logic [7:0] frag_len_i = 8'd1, blk_len_i = 8'd1, trans_len_i = 8'd1, list_len_i = 8'd1;
    logic [1:0] req_mode_i = 2'd0;
    logic [3:0] irq_type_i = 4'd0;
    logic       frag_done_o, blk_done_o, trans_done_o, list_done_o, req_done_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    int  mf, mb, mt, ml;
    bit  marmed, mirq;
    int  FL, BL, TL, LL, MODE, ITYP;

    always #2.5 clk = ~clk;

    dma_hier_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .beat_ack_i(beat_ack_i),
        .frag_len_i(frag_len_i), .blk_len_i(blk_len_i), .trans_len_i(trans_len_i),
        .list_len_i(list_len_i), .req_mode_i(req_mode_i), .irq_type_i(irq_type_i),
        .irq_clr_i(irq_clr_i), .frag_done_o(frag_done_o), .blk_done_o(blk_done_o),
        .trans_done_o(trans_done_o), .list_done_o(list_done_o),
        .req_done_o(req_done_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, nm, act, exp, $time);
        end
    endtask

    function automatic bit cfg_valid();
        return FL > 0 && BL > 0 && TL > 0 && LL > 0 && FL <= BL && BL <= TL;
    endfunction

    // One cycle: drive, compare every output with the model, then advance the model
    task automatic cyc(input bit r, input bit a, input bit c);
        bit beat, te, be, fe, le, rd, ce, ev, ok;
        string lf, lr;
        @(negedge clk);
        req_i = r; beat_ack_i = a; irq_clr_i = c;
        #1;
        ok   = cfg_valid();
        beat = marmed && a;
        te   = beat && (mt + 1 == TL);
        be   = beat && (te || (mb + 1 == BL));
        fe   = beat && (be || (mf + 1 == FL));
        le   = te && (ml + 1 == LL);
        case (MODE)
            0: rd = fe;
            1: rd = be;
            2: rd = te;
            default: rd = le;
        endcase
        ce = r && !marmed && !ok;
        lf = marmed ? "R2" : "R7";
        lr = ok ? (marmed ? "R6" : "R7") : "R1";
        chk(lf, "frag_done", frag_done_o, fe);
        chk(marmed ? "R3" : "R7", "blk_done", blk_done_o, be);
        chk(marmed ? "R4" : "R7", "trans_done", trans_done_o, te);
        chk(marmed ? "R5" : "R7", "list_done", list_done_o, le);
        chk(lr, "req_done", req_done_o, rd);
        chk(ok ? "R8/R9" : "R1", "irq", irq_o, mirq);
        if (beat) begin
            mf = fe ? 0 : mf + 1;
            mb = be ? 0 : mb + 1;
            mt = te ? 0 : mt + 1;
            if (te) ml = le ? 0 : ml + 1;
        end
        if (marmed && rd)              marmed = 1'b0;
        else if (!marmed && r && ok)   marmed = 1'b1;
        case (ITYP)
            1: ev = fe;
            2: ev = be;
            3: ev = be || fe;
            4: ev = te;
            5: ev = te || fe;
            6: ev = te || be;
            7: ev = le;
            8: ev = ce;
            default: ev = 1'b0;
        endcase
        mirq = (mirq && !c) || ev;
    endtask

    // Reset the DUT and the model, program a configuration, check the reset state
    task automatic setup(input int fl, input int bl, input int tl, input int ll,
                         input int mode, input int ityp);
        FL = fl; BL = bl; TL = tl; LL = ll; MODE = mode; ITYP = ityp;
        @(negedge clk);
        rst_n = 1'b0; req_i = 0; beat_ack_i = 0; irq_clr_i = 0;
        frag_len_i = 8'(fl); blk_len_i = 8'(bl); trans_len_i = 8'(tl); list_len_i = 8'(ll);
        req_mode_i = 2'(mode); irq_type_i = 4'(ityp);
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R10", "frag_done_rst", frag_done_o, 1'b0);
        chk("R10", "req_done_rst", req_done_o, 1'b0);
        chk("R10", "irq_rst", irq_o, 1'b0);
        rst_n = 1'b1;
        mf = 0; mb = 0; mt = 0; ml = 0; marmed = 0; mirq = 0;
        // R10: idle after reset, a beat alone must not count
        cyc(1'b0, 1'b1, 1'b0);
    endtask

    task automatic run_rand(input int n);
        for (int i = 0; i < n; i++)
            cyc(($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 8) == 0);
    endtask

    initial begin
        // Valid hierarchies over every request mode and interrupt code (R2-R6, R8, R9)
        for (int k = 0; k < 4; k++) begin
            for (int it = 0; it < 10; it++) begin
                for (int m = 0; m < 4; m++) begin
                    case (k)
                        0: setup(2, 5, 10, 2, m, it);
                        1: setup(1, 1, 1, 1, m, it);
                        2: setup(3, 3, 9, 3, m, it);
                        default: setup(4, 7, 7, 1, m, it);
                    endcase
                    run_rand(60);
                end
            end
        end
        // R7: requests while armed and beats while idle, directed
        setup(2, 4, 8, 2, 2, 4);
        cyc(1, 0, 0); cyc(1, 1, 0); cyc(1, 1, 0); cyc(1, 1, 0);
        for (int i = 0; i < 8; i++) cyc(0, 1, 0);
        // R9: clear coinciding with a new event keeps the line high
        setup(1, 1, 1, 1, 3, 1);
        cyc(1, 0, 0); cyc(0, 1, 0); cyc(1, 0, 0); cyc(0, 1, 1); cyc(0, 0, 0);
        cyc(0, 0, 1); cyc(0, 0, 0);
        // R1: invalid configurations refuse the request and may raise an error interrupt
        for (int it = 7; it < 10; it++) begin
            setup(0, 4, 8, 2, 0, it); run_rand(20);
            setup(5, 4, 8, 2, 1, it); run_rand(20);
            setup(2, 9, 8, 2, 2, it); run_rand(20);
            setup(2, 4, 8, 0, 3, it); run_rand(20);
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule